// File: doc/BRIEF.md
# Ring-Buffer Capture Interrupt Counter

This block steers one capture substream into a circular region of delay memory. The host sets a memory base, a ring length in frames, a channel count, an interrupt period and a trigger. While the substream is active, each sample tick latches one multichannel frame. The block then issues one memory write per channel on consecutive cycles. Every channel owns its own plane of the ring, so channel `i` of a frame lands at `base + i*size + ptr`.

At the end of each frame the ring pointer advances and wraps, and a countdown steps down. When the countdown reaches its interrupt point, the block raises a one-cycle interrupt and reloads the countdown from the period. The host can clear the pointer and load the countdown directly at any time. The block reports the pointer, the countdown and a running flag. The running flag only changes between frames, so a stop request never cuts a frame short.

Top module: `ring_capture_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `cur_ptr`, `countdown`, `running`, `irq` and `mem_we` are all 0.
- R2: While no frame is in progress, `running` becomes `host_trigger && cfg_chans != 0` at the next clock edge. With `cfg_chans` equal to 0, `running` stays low even when triggered.
- R3: When `sample_tick` is high in an idle cycle with `running` high, the frame on `sample_in` is latched. From the next cycle on, `mem_we` is high for exactly N consecutive cycles, where N is the channel count. Write `i` carries lane `i` (bits `i*DATA_W` upward) at address `cfg_base + i*cfg_size + cur_ptr`, taken modulo 2^ADDR_W.
- R4: At the edge that ends a frame, `cur_ptr` becomes `cur_ptr+1`, or 0 when `cur_ptr+1 >= cfg_size`.
- R5: At the edge that ends a frame, if `countdown` is 0 or 1 then `irq` is high for exactly the following cycle and `countdown` reloads from `cfg_period`. Otherwise `countdown` decreases by one.
- R6: `host_cnt_set` loads `host_cnt_val` into `countdown` at the next edge. This load takes priority over the engine's reload or decrement, while `irq` is still decided from the old count.
- R7: `host_ptr_clr` forces `cur_ptr` to 0 at the next edge, and takes priority over an advance in the same cycle.
- R8: Dropping `host_trigger` during a frame lets that frame finish, and `running` falls at the edge that ends it. Ticks while `running` is low produce no write and leave `cur_ptr` and `countdown` unchanged.
- R9: Ticks that arrive while a frame is being written are ignored, so one frame advances the pointer exactly once.
- R10: A `cfg_chans` value above MAX_CH is treated as MAX_CH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | ADDR_W | Ring start offset in delay memory |
| cfg_size | input | SIZE_W | Ring length in frames |
| cfg_chans | input | CH_W | Channels per frame, 0 disables |
| cfg_period | input | CNT_W | Frames between interrupts (reload value) |
| host_trigger | input | 1 | Host request to run the substream |
| host_ptr_clr | input | 1 | Host pulse clearing the ring pointer |
| host_cnt_set | input | 1 | Host pulse loading the countdown |
| host_cnt_val | input | CNT_W | Value loaded by host_cnt_set |
| sample_tick | input | 1 | One pulse per sample period |
| sample_in | input | MAX_CH*DATA_W | Frame lanes, lane i at bits i*DATA_W |
| mem_we | output | 1 | Delay-memory write strobe |
| mem_addr | output | ADDR_W | Delay-memory write address |
| mem_wdata | output | DATA_W | Delay-memory write data |
| cur_ptr | output | SIZE_W | Current ring position |
| countdown | output | CNT_W | Frames left to the next interrupt |
| running | output | 1 | Substream active |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Two kinds of same-cycle conflict are tested. In the first, the host's pointer clear or countdown load is asserted in the very cycle that ends a frame, so the host write collides with the engine's advance, reload or decrement. The bench drives the pulse during the last write cycle and expects the host value to win, with `irq` still following the old count. In the second, the trigger is dropped while channels are still being written. The bench expects every remaining write and a single pointer advance, with `running` falling only at the frame's closing edge.

// File: rtl/cap_pkg.sv
// Shared types for the ring capture controller.
package cap_pkg;
    // Frame sequencer phase: waiting for a tick, or writing channels.
    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_WRITE = 1'b1
    } seq_state_e;
endpackage

// File: rtl/cap_ptr_ring.sv
// Ring pointer unit.
// Holds the current frame position in the ring. The engine advances it by one
// per frame and it wraps to zero when the next position reaches the size.
// The host clear takes priority over an advance in the same cycle.
// Assumes cfg_size is held while frames are in progress.
module cap_ptr_ring #(
    parameter int SIZE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              advance,
    input  logic [SIZE_W-1:0] size,
    output logic [SIZE_W-1:0] ptr
);
    logic [SIZE_W:0]   nxt_wide;
    logic [SIZE_W-1:0] ptr_q;

    // Next position with a spare bit so that size at its maximum still compares.
    always_comb begin
        nxt_wide = {1'b0, ptr_q} + {{SIZE_W{1'b0}}, 1'b1};
    end

    // Pointer register: host clear, then engine advance with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (clr) begin
            ptr_q <= '0;
        end else if (advance) begin
            ptr_q <= (nxt_wide >= {1'b0, size}) ? '0 : nxt_wide[SIZE_W-1:0];
        end
    end

    assign ptr = ptr_q;

    // R7: a host clear always leaves the pointer at zero.
    p_clr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ptr == '0));

    // R4: after an advance the pointer lies inside the ring.
    p_ptr_in_ring_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clr && size != '0) |=> (ptr < $past(size)));

    // R8: without an advance or a clear the pointer does not move.
    p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !clr) |=> $stable(ptr));
endmodule

// File: rtl/cap_period_cnt.sv
// Interrupt period countdown.
// Steps down once per completed frame. At 0 or 1 it raises a registered
// one-cycle interrupt and reloads from the period. A host load takes priority
// over the engine's update, but the interrupt still follows the old count.
// Assumes step pulses are at least two cycles apart.
module cap_period_cnt #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             host_set,
    input  logic [CNT_W-1:0] host_val,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             irq
);
    logic [CNT_W-1:0] cnt_q;
    logic             irq_q;
    logic             hit;

    // Interrupt point: a frame completes while the count is at 0 or 1.
    always_comb begin
        hit = step && (cnt_q <= CNT_W'(1));
    end

    // Countdown and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= hit;
            if (host_set) begin
                cnt_q <= host_val;
            end else if (hit) begin
                cnt_q <= period;
            end else if (step) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign cnt = cnt_q;
    assign irq = irq_q;

    // R5: the interrupt lasts a single cycle.
    p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R5: an ordinary frame takes exactly one off the count.
    p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !host_set && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - CNT_W'(1)));

    // R6: a host load is visible one cycle later.
    p_host_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_set |=> (cnt == $past(host_val)));
endmodule

// File: rtl/cap_frame_seq.sv
// Frame sequencer.
// Accepts a sample tick while running and idle, latches the frame, and emits
// one delay-memory write per channel on consecutive cycles. Channel i goes to
// base + i*size + ptr. The running flag is only updated between frames.
// Assumes base, size and ptr stay still while a frame is written (ptr only
// moves at frame end).
module cap_frame_seq
    import cap_pkg::*;
#(
    parameter int MAX_CH = 4,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 10,
    parameter int CH_W   = $clog2(MAX_CH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     trigger,
    input  logic [CH_W-1:0]          chans,
    input  logic [ADDR_W-1:0]        base,
    input  logic [SIZE_W-1:0]        size,
    input  logic [SIZE_W-1:0]        ptr,
    input  logic                     tick,
    input  logic [MAX_CH*DATA_W-1:0] frame_in,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    output logic                     running,
    output logic                     frame_done
);
    localparam int CHI_W = (MAX_CH > 1) ? $clog2(MAX_CH) : 1;

    seq_state_e               state_q;
    logic [CH_W-1:0]          ch_q;
    logic [CH_W-1:0]          last_ch_q;
    logic [ADDR_W-1:0]        off_q;
    logic [MAX_CH*DATA_W-1:0] frame_q;
    logic                     running_q;
    logic [CH_W-1:0]          chans_eff;
    logic                     run_cond;
    logic                     accept;
    logic [DATA_W-1:0]        lanes [MAX_CH];

    // Clamp the channel count to the number of lanes.
    always_comb begin
        chans_eff = (chans > CH_W'(MAX_CH)) ? CH_W'(MAX_CH) : chans;
        run_cond  = trigger && (chans != '0);
        accept    = (state_q == SEQ_IDLE) && running_q && tick;
        frame_done = (state_q == SEQ_WRITE) && (ch_q == last_ch_q);
    end

    // Split the latched frame into lanes.
    for (genvar g = 0; g < MAX_CH; g++) begin : g_lane
        assign lanes[g] = frame_q[g*DATA_W +: DATA_W];
    end

    // Sequencer state, channel index, plane offset and frame latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SEQ_IDLE;
            ch_q      <= '0;
            last_ch_q <= '0;
            off_q     <= '0;
            frame_q   <= '0;
        end else if (accept) begin
            state_q   <= SEQ_WRITE;
            ch_q      <= '0;
            last_ch_q <= chans_eff - CH_W'(1);
            off_q     <= '0;
            frame_q   <= frame_in;
        end else if (state_q == SEQ_WRITE) begin
            if (frame_done) begin
                state_q <= SEQ_IDLE;
            end
            ch_q  <= ch_q + CH_W'(1);
            off_q <= off_q + ADDR_W'(size);
        end
    end

    // Running flag: follows the host only outside frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
        end else if ((state_q == SEQ_IDLE && !accept) || frame_done) begin
            running_q <= run_cond;
        end
    end

    assign mem_we    = (state_q == SEQ_WRITE);
    assign mem_addr  = base + off_q + ADDR_W'(ptr);
    assign mem_wdata = lanes[ch_q[CHI_W-1:0]];
    assign running   = running_q;

    // R8: writes only happen while the substream runs.
    p_we_needs_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> running);

    // R8: running falls only outside a frame or at its closing edge.
    p_run_drop_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> ($past(state_q) == SEQ_IDLE || $past(frame_done)));

    // R3: channels are written in ascending order without gaps.
    p_ch_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !frame_done) |=> (mem_we && ch_q == $past(ch_q) + CH_W'(1)));

    // R10: a frame never writes more channels than there are lanes.
    p_ch_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (ch_q < CH_W'(MAX_CH)));
endmodule

// File: rtl/ring_capture_ctrl.sv
// Ring-buffer capture controller, top level.
// Joins the frame sequencer, the ring pointer and the interrupt countdown.
// A completed frame advances the pointer and steps the countdown in the same
// edge. Assumes sample ticks are spaced at least N+1 cycles apart for N
// channels (closer ticks are dropped), and SIZE_W <= ADDR_W.
module ring_capture_ctrl #(
    parameter int MAX_CH = 4,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 10,
    parameter int CNT_W  = 10,
    parameter int CH_W   = $clog2(MAX_CH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        cfg_base,
    input  logic [SIZE_W-1:0]        cfg_size,
    input  logic [CH_W-1:0]          cfg_chans,
    input  logic [CNT_W-1:0]         cfg_period,
    input  logic                     host_trigger,
    input  logic                     host_ptr_clr,
    input  logic                     host_cnt_set,
    input  logic [CNT_W-1:0]         host_cnt_val,
    input  logic                     sample_tick,
    input  logic [MAX_CH*DATA_W-1:0] sample_in,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    output logic [SIZE_W-1:0]        cur_ptr,
    output logic [CNT_W-1:0]         countdown,
    output logic                     running,
    output logic                     irq
);
    logic frame_done;

    // Frame sequencer: tick acceptance, per-channel writes, running flag.
    cap_frame_seq #(
        .MAX_CH (MAX_CH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W),
        .CH_W   (CH_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .trigger    (host_trigger),
        .chans      (cfg_chans),
        .base       (cfg_base),
        .size       (cfg_size),
        .ptr        (cur_ptr),
        .tick       (sample_tick),
        .frame_in   (sample_in),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .running    (running),
        .frame_done (frame_done)
    );

    // Ring pointer: advanced per frame, cleared by the host.
    cap_ptr_ring #(
        .SIZE_W (SIZE_W)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (host_ptr_clr),
        .advance (frame_done),
        .size    (cfg_size),
        .ptr     (cur_ptr)
    );

    // Interrupt countdown: stepped per frame, loaded by the host.
    cap_period_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (frame_done),
        .host_set (host_cnt_set),
        .host_val (host_cnt_val),
        .period   (cfg_period),
        .cnt      (countdown),
        .irq      (irq)
    );

    // R5: an interrupt is always the result of a frame that just closed.
    p_irq_after_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(frame_done));
endmodule

// File: tb/ring_capture_ctrl_tb_top.sv
`timescale 1ns/1ps
module ring_capture_ctrl_tb_top;
    localparam int MAX_CH = 4;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 16;
    localparam int SIZE_W = 10;
    localparam int CNT_W  = 10;
    localparam int CH_W   = $clog2(MAX_CH + 1);

    logic                     clk = 1'b0;
    logic                     rst_n;
    logic [ADDR_W-1:0]        cfg_base;
    logic [SIZE_W-1:0]        cfg_size;
    logic [CH_W-1:0]          cfg_chans;
    logic [CNT_W-1:0]         cfg_period;
    logic                     host_trigger;
    logic                     host_ptr_clr;
    logic                     host_cnt_set;
    logic [CNT_W-1:0]         host_cnt_val;
    logic                     sample_tick;
    logic [MAX_CH*DATA_W-1:0] sample_in;
    logic                     mem_we;
    logic [ADDR_W-1:0]        mem_addr;
    logic [DATA_W-1:0]        mem_wdata;
    logic [SIZE_W-1:0]        cur_ptr;
    logic [CNT_W-1:0]         countdown;
    logic                     running;
    logic                     irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Bench model of the host-visible state.
    int mptr = 0;
    int mcnt = 0;

    always #2 clk = ~clk;

    ring_capture_ctrl #(
        .MAX_CH (MAX_CH), .DATA_W (DATA_W), .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W), .CNT_W (CNT_W), .CH_W (CH_W)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .cfg_base (cfg_base), .cfg_size (cfg_size), .cfg_chans (cfg_chans),
        .cfg_period (cfg_period), .host_trigger (host_trigger),
        .host_ptr_clr (host_ptr_clr), .host_cnt_set (host_cnt_set),
        .host_cnt_val (host_cnt_val), .sample_tick (sample_tick),
        .sample_in (sample_in), .mem_we (mem_we), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .cur_ptr (cur_ptr), .countdown (countdown),
        .running (running), .irq (irq)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int eff_ch(input int c);
        return (c > MAX_CH) ? MAX_CH : c;
    endfunction

    function automatic int exp_addr(input int b, input int s, input int c, input int p);
        return (b + c * s + p) & ((1 << ADDR_W) - 1);
    endfunction

    function automatic int next_ptr(input int p, input int s);
        return (p + 1 >= s) ? 0 : p + 1;
    endfunction

    // One frame: tick, check each write, optional host conflicts, check results.
    // opts bit0: clear pointer at frame end, bit1: load countdown at frame end,
    // bit2: extra tick during the frame, bit3: drop trigger during the frame.
    task automatic run_frame(input logic [MAX_CH*DATA_W-1:0] data, input int opts,
                             input int set_val);
        int n;
        bit irq_e;
        n = eff_ch(int'(cfg_chans));
        @(negedge clk);
        sample_tick = 1'b1;
        sample_in   = data;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            sample_tick = (c == 0 && opts[2] && n > 1);
            if (c == 0 && opts[3]) host_trigger = 1'b0;
            chk(mem_we == 1'b1, "R3 write strobe", mem_we, 1);
            chk(int'(mem_addr) == exp_addr(int'(cfg_base), int'(cfg_size), c, mptr),
                "R3 write address", mem_addr,
                exp_addr(int'(cfg_base), int'(cfg_size), c, mptr));
            chk(mem_wdata == data[c*DATA_W +: DATA_W], "R3 write lane", mem_wdata,
                data[c*DATA_W +: DATA_W]);
            if (c == n - 1) begin
                host_ptr_clr = opts[0];
                host_cnt_set = opts[1];
                host_cnt_val = CNT_W'(set_val);
            end
        end
        @(negedge clk);
        sample_tick  = 1'b0;
        host_ptr_clr = 1'b0;
        host_cnt_set = 1'b0;
        irq_e = (mcnt <= 1);
        if (opts[1])      mcnt = set_val;
        else if (irq_e)   mcnt = int'(cfg_period);
        else              mcnt = mcnt - 1;
        mptr = opts[0] ? 0 : next_ptr(mptr, int'(cfg_size));
        chk(int'(cur_ptr) == mptr, opts[0] ? "R7 clear wins" : "R4 pointer advance",
            cur_ptr, mptr);
        chk(int'(countdown) == mcnt, opts[1] ? "R6 load wins" : "R5 countdown",
            countdown, mcnt);
        chk(irq == irq_e, "R5 irq pulse", irq, irq_e);
        chk(mem_we == 1'b0, "R9 single frame per tick", mem_we, 0);
        chk(running == !opts[3], "R8 running at boundary", running, !opts[3]);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [MAX_CH*DATA_W-1:0] d;
        void'($urandom(32'h5eed_0417));
        rst_n = 1'b0; cfg_base = '0; cfg_size = 10'd4; cfg_chans = 3'd2;
        cfg_period = 10'd3; host_trigger = 1'b0; host_ptr_clr = 1'b0;
        host_cnt_set = 1'b0; host_cnt_val = '0; sample_tick = 1'b0; sample_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cur_ptr == '0, "R1 ptr", cur_ptr, 0);
        chk(countdown == '0, "R1 countdown", countdown, 0);
        chk(running == 1'b0, "R1 running", running, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        chk(mem_we == 1'b0, "R1 we", mem_we, 0);

        // R2: zero channels keeps the substream off
        cfg_chans = '0; host_trigger = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(running == 1'b0, "R2 zero channels", running, 0);
        // R8: tick while stopped writes nothing, changes nothing
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
        chk(mem_we == 1'b0, "R8 no write when stopped", mem_we, 0);
        chk(int'(cur_ptr) == mptr && int'(countdown) == mcnt, "R8 state kept",
            cur_ptr, mptr);
        // R2: running rises one edge after enabling
        cfg_chans = 3'd2;
        @(negedge clk);
        chk(running == 1'b1, "R2 running rises", running, 1);

        // Directed: wrap at size 4 with countdown from 0
        cfg_base = 16'hFFF0;
        for (int i = 0; i < 6; i++) run_frame({$urandom, $urandom}, 0, 0);
        // R6 and R7 conflicts at frame end
        run_frame({$urandom, $urandom}, 1, 0);
        run_frame({$urandom, $urandom}, 2, 5);
        run_frame({$urandom, $urandom}, 3, 1);
        // R6: host load while idle
        host_cnt_set = 1'b1; host_cnt_val = 10'd7;
        @(negedge clk);
        host_cnt_set = 1'b0; mcnt = 7;
        chk(int'(countdown) == 7, "R6 idle load", countdown, 7);
        // R7: host clear while idle
        host_ptr_clr = 1'b1;
        @(negedge clk);
        host_ptr_clr = 1'b0; mptr = 0;
        chk(cur_ptr == '0, "R7 idle clear", cur_ptr, 0);
        // R9: extra tick during a frame
        run_frame({$urandom, $urandom}, 4, 0);
        // R10: channel count above lanes is clamped
        cfg_chans = 3'd7;
        run_frame({$urandom, $urandom}, 0, 0);
        // R8: trigger dropped mid-frame
        run_frame({$urandom, $urandom}, 8, 0);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
        chk(mem_we == 1'b0, "R8 stopped after drop", mem_we, 0);
        chk(int'(cur_ptr) == mptr, "R8 ptr held", cur_ptr, mptr);

        // Constrained random frames
        for (int it = 0; it < 40; it++) begin
            int op;
            cfg_chans  = CH_W'(1 + $urandom % MAX_CH);
            cfg_size   = SIZE_W'(1 + $urandom % 7);
            cfg_period = CNT_W'($urandom % 5);
            cfg_base   = ADDR_W'($urandom);
            host_trigger = 1'b1;
            @(negedge clk);
            for (int f = 0; f < 3; f++) begin
                d  = {$urandom, $urandom};
                op = (($urandom % 8) == 0 ? 1 : 0) | (($urandom % 8) == 0 ? 2 : 0)
                   | (($urandom % 4) == 0 ? 4 : 0);
                run_frame(d, op, int'($urandom % 6));
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule